// File: doc/BRIEF.md
# Dual-Width Timer/Counter with Compare Blocking

This block is an up-counter that works either as one 8-bit counter or as one 16-bit counter. It has two output-compare channels, an overflow flag, two compare flags, and an interrupt request for each flag. It advances only in cycles where the prescaled count-enable pulse is high, so each such cycle is one timer clock. A register-write side port loads the counter and the two compare registers. Flags are cleared either by writing ones to a clear vector or by an acknowledge from the interrupt controller.

A 3-bit mode field selects the counting behaviour. The two capture-enabled modes count exactly like the normal modes of the same width; capture latching itself lives outside this block. In 16-bit operation only channel A compares, using all sixteen bits. Writing the counter arms a one-shot blocker that suppresses every compare match in the next timer clock. Software can therefore load a counter value equal to a compare value without raising a match.

Top module: `dual_width_timer`

## Requirements
- R1: `mode_sel` is {capture-enable, width, clear-on-compare}. 3'b000 selects normal 8-bit and 3'b001 selects clear-on-compare 8-bit. 3'b010 and 3'b011 select normal 16-bit. 3'b100 and 3'b101 select capture 8-bit. 3'b110 and 3'b111 select capture 16-bit. Capture modes count like the normal mode of the same width.
- R2: In the 8-bit modes, each count-enable cycle increments the low byte, which wraps from 0xFF to 0x00, and leaves the high byte at zero. A counter write in these modes stores the low data byte and clears the high byte.
- R3: In the 16-bit modes, each count-enable cycle increments all sixteen bits, which wrap from 0xFFFF to 0x0000.
- R4: After reset the counter, the flags and `irq` are zero. The counter holds when `tick_en` is low. A counter write wins over a tick in the same cycle, and the written value appears on `cnt_q` in the next cycle.
- R5: The overflow flag (`flags_q` bit 0) is set after a count-enable cycle, with no counter write, in which the counter is at MAX. MAX is 0xFF in the 8-bit modes and 0xFFFF in the 16-bit modes.
- R6: In a count-enable cycle that is not blocked and has no counter write: in the 8-bit modes, a low-byte match with compare A sets `flags_q` bit 1, and a low-byte match with compare B sets bit 2. In the 16-bit modes, a full 16-bit match with compare A sets bit 1, and bit 2 is never set.
- R7: In clear-on-compare 8-bit mode, a count-enable cycle that raises an unblocked compare-A match loads the counter with 0 instead of incrementing it.
- R8: A counter write blocks all compare matches, including the clear-on-compare reload, in the next count-enable cycle. Any number of disabled cycles may come between the write and that cycle. Later count-enable cycles match normally.
- R9: A compare register write takes effect in the next cycle in every mode, with no buffering.
- R10: Each flag is cleared by a one in its bit of `flag_clr` or of `irq_ack`. A set event in the same cycle overrides the clear.
- R11: `irq` bit i is high exactly while flag i is set and `irq_en` bit i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | {capture-enable, width, clear-on-compare} |
| tick_en | input | 1 | Prescaled count-enable pulse |
| cnt_wr | input | 1 | Write strobe for the counter |
| cnt_wdata | input | 16 | Counter write data |
| cmpa_wr | input | 1 | Write strobe for compare register A |
| cmpb_wr | input | 1 | Write strobe for compare register B |
| cmp_wdata | input | 16 | Compare register write data |
| flag_clr | input | 3 | Write-one-to-clear: bit0 overflow, bit1 A, bit2 B |
| irq_ack | input | 3 | Interrupt acknowledge, same bit order |
| irq_en | input | 3 | Interrupt enables, same bit order |
| cnt_q | output | 16 | Current counter value |
| flags_q | output | 3 | Flag state, same bit order |
| irq | output | 3 | Interrupt requests, same bit order |

## Verification
The hardest case to reach from the ports is a blocked match that lands exactly on a compare value. It needs a counter write equal to compare A or B, then one or more idle cycles, then the first tick. A second tick must then show that blocking has ended. Directed sequences build this case in 8-bit, 16-bit and clear-on-compare modes. The random phase keeps compare values and counter writes in a small range so that writes often hit live compare values. A bench model tracks the pending block and checks counter, flags and requests every cycle.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  typedef enum logic [2:0] {
    MODE_NORM8,
    MODE_CLR8,
    MODE_NORM16,
    MODE_CAPT8,
    MODE_CAPT16
  } tmode_e;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLG_OVF   = 0;
  localparam int unsigned FLG_CMPA  = 1;
  localparam int unsigned FLG_CMPB  = 2;
  localparam int unsigned NUM_CH    = 2;

  // bit 2: capture enable, bit 1: width, bit 0: clear-on-compare
  function automatic tmode_e decode_mode(input logic [2:0] sel);
    tmode_e m;
    unique casez (sel)
      3'b000:  m = MODE_NORM8;
      3'b001:  m = MODE_CLR8;
      3'b01?:  m = MODE_NORM16;
      3'b10?:  m = MODE_CAPT8;
      default: m = MODE_CAPT16;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dwt_rst_sync.sv
module dwt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dwt_mode_dec.sv
module dwt_mode_dec
  import dwt_pkg::*;
(
  input  logic [2:0] mode_sel,
  output logic       wide,
  output logic       clr_on_a
);
  tmode_e mode;

  always_comb begin
    mode     = decode_mode(mode_sel);
    wide     = (mode == MODE_NORM16) || (mode == MODE_CAPT16);
    clr_on_a = (mode == MODE_CLR8);
  end
endmodule

// File: rtl/dwt_counter.sv
module dwt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             clr_on_a,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             match_a,
  output logic [CNT_W-1:0] cnt_q,
  output logic             blk_q,
  output logic             ovf_evt
);
  localparam int unsigned   LO_W   = CNT_W / 2;
  localparam int unsigned   HI_W   = CNT_W - LO_W;
  localparam logic [CNT_W-1:0] ONE_F = CNT_W'(1);
  localparam logic [LO_W-1:0]  ONE_L = LO_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             blk_d;
  logic [LO_W-1:0]  lo_inc;
  logic             at_max;

  always_comb begin
    cnt_d   = cnt_q;
    blk_d   = blk_q;
    lo_inc  = cnt_q[LO_W-1:0] + ONE_L;
    at_max  = wide ? (&cnt_q) : (&cnt_q[LO_W-1:0]);
    ovf_evt = tick_en && !wr_en && at_max;
    if (wr_en) begin
      cnt_d = wide ? wr_data : {{HI_W{1'b0}}, wr_data[LO_W-1:0]};
      blk_d = 1'b1;
    end else if (tick_en) begin
      blk_d = 1'b0;
      if (clr_on_a && match_a) cnt_d = '0;
      else if (wide)           cnt_d = cnt_q + ONE_F;
      else                     cnt_d = {{HI_W{1'b0}}, lo_inc};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      blk_q <= blk_d;
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> $stable(cnt_q));

  assert_ctc_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_en && clr_on_a && match_a) |=> (cnt_q == '0));

  assert_block_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> blk_q);
endmodule

// File: rtl/dwt_compare.sv
module dwt_compare
  import dwt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              tick_en,
  input  logic              cnt_wr,
  input  logic              blk,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [NUM_CH-1:0] ocr_wr,
  input  logic [CNT_W-1:0]  ocr_wdata,
  output logic [NUM_CH-1:0] match
);
  localparam int unsigned LO_W = CNT_W / 2;

  logic live;
  assign live = tick_en && !cnt_wr && !blk;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] ocr_q;
    logic             eq_full;
    logic             eq_low;
    logic             ch_on;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ocr_q <= '0;
      else if (ocr_wr[ch]) ocr_q <= ocr_wdata;
    end

    always_comb begin
      eq_full   = (cnt == ocr_q);
      eq_low    = (cnt[LO_W-1:0] == ocr_q[LO_W-1:0]);
      ch_on     = (ch == 0) ? 1'b1 : !wide;
      match[ch] = live && ch_on && (wide ? eq_full : eq_low);
    end
  end

  assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk |-> (match == '0));

  assert_b_silent_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> !match[1]);
endmodule

// File: rtl/dwt_flags.sv
module dwt_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_wr,
  input  logic [N-1:0] ack,
  output logic [N-1:0] flags_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_d;

    always_comb begin
      flag_d = flags_q[i];
      if (clr_wr[i] || ack[i]) flag_d = 1'b0;
      if (set_evt[i])          flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flag_d;
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flags_q[i]);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_evt[i] && (clr_wr[i] || ack[i])) |=> !flags_q[i]);
  end
endmodule

// File: rtl/dual_width_timer.sv
module dual_width_timer
  import dwt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           mode_sel,
  input  logic                 tick_en,
  input  logic                 cnt_wr,
  input  logic [CNT_W-1:0]     cnt_wdata,
  input  logic                 cmpa_wr,
  input  logic                 cmpb_wr,
  input  logic [CNT_W-1:0]     cmp_wdata,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  input  logic [NUM_FLAGS-1:0] irq_ack,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic [CNT_W-1:0]     cnt_q,
  output logic [NUM_FLAGS-1:0] flags_q,
  output logic [NUM_FLAGS-1:0] irq
);
  logic              rst_n_s;
  logic              wide;
  logic              clr_on_a;
  logic              blk;
  logic              ovf_evt;
  logic [NUM_CH-1:0] match;
  logic [NUM_FLAGS-1:0] set_evt;

  dwt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dwt_mode_dec u_dec (
    .mode_sel (mode_sel),
    .wide     (wide),
    .clr_on_a (clr_on_a)
  );

  dwt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wide     (wide),
    .clr_on_a (clr_on_a),
    .tick_en  (tick_en),
    .wr_en    (cnt_wr),
    .wr_data  (cnt_wdata),
    .match_a  (match[0]),
    .cnt_q    (cnt_q),
    .blk_q    (blk),
    .ovf_evt  (ovf_evt)
  );

  dwt_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wide      (wide),
    .tick_en   (tick_en),
    .cnt_wr    (cnt_wr),
    .blk       (blk),
    .cnt       (cnt_q),
    .ocr_wr    ({cmpb_wr, cmpa_wr}),
    .ocr_wdata (cmp_wdata),
    .match     (match)
  );

  always_comb begin
    set_evt           = '0;
    set_evt[FLG_OVF]  = ovf_evt;
    set_evt[FLG_CMPA] = match[0];
    set_evt[FLG_CMPB] = match[1];
  end

  dwt_flags #(.N(NUM_FLAGS)) u_flg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .set_evt (set_evt),
    .clr_wr  (flag_clr),
    .ack     (irq_ack),
    .flags_q (flags_q)
  );

  assign irq = flags_q & irq_en;

  assert_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tick_en && !cnt_wr && (wide ? (&cnt_q) : (&cnt_q[CNT_W/2-1:0]))) |=> flags_q[FLG_OVF]);

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_en == '0) |-> (irq == '0));
endmodule

// File: tb/dual_width_timer_bench.sv
module dual_width_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode_sel;
  logic        tick_en, cnt_wr, cmpa_wr, cmpb_wr;
  logic [15:0] cnt_wdata, cmp_wdata;
  logic [2:0]  flag_clr, irq_ack, irq_en;
  logic [15:0] cnt_q;
  logic [2:0]  flags_q, irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] m_cnt, m_ocra, m_ocrb;
  logic [2:0]  m_flags;
  logic        m_blk;

  always #2 clk = ~clk;

  dual_width_timer u_dual_width_timer (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tick_en(tick_en),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmpa_wr(cmpa_wr), .cmpb_wr(cmpb_wr),
    .cmp_wdata(cmp_wdata), .flag_clr(flag_clr), .irq_ack(irq_ack), .irq_en(irq_en),
    .cnt_q(cnt_q), .flags_q(flags_q), .irq(irq)
  );

  function automatic logic is_wide(input logic [2:0] m);
    return m[1];
  endfunction

  function automatic logic is_ctc(input logic [2:0] m);
    return m == 3'b001;
  endfunction

  task automatic check(input string tag);
    logic [2:0] exp_irq;
    exp_irq = m_flags & irq_en;
    vectors++;
    if (cnt_q !== m_cnt || flags_q !== m_flags || irq !== exp_irq) begin
      miscompares++;
      $display("FAIL %s: cnt=%h flags=%b irq=%b expected cnt=%h flags=%b irq=%b",
               tag, cnt_q, flags_q, irq, m_cnt, m_flags, exp_irq);
    end
  endtask

  // Drive current inputs for one cycle (called at a negedge), update model, check.
  task automatic step(input string tag);
    logic        w, live, ma, mb, ov;
    logic [15:0] nc;
    logic [2:0]  nf, setv;
    w    = is_wide(mode_sel);
    live = tick_en && !cnt_wr && !m_blk;
    ma   = live && (w ? (m_cnt == m_ocra) : (m_cnt[7:0] == m_ocra[7:0]));
    mb   = live && !w && (m_cnt[7:0] == m_ocrb[7:0]);
    ov   = tick_en && !cnt_wr && (w ? (m_cnt == 16'hFFFF) : (m_cnt[7:0] == 8'hFF));
    if (cnt_wr)       nc = w ? cnt_wdata : {8'h00, cnt_wdata[7:0]};
    else if (tick_en) nc = (is_ctc(mode_sel) && ma) ? 16'h0000 :
                           (w ? m_cnt + 16'd1 : {8'h00, m_cnt[7:0] + 8'd1});
    else              nc = m_cnt;
    setv = {mb, ma, ov};
    nf   = setv | (m_flags & ~flag_clr & ~irq_ack);
    @(negedge clk);
    m_cnt   = nc;
    m_flags = nf;
    if (cnt_wr) m_blk = 1'b1; else if (tick_en) m_blk = 1'b0;
    if (cmpa_wr) m_ocra = cmp_wdata;
    if (cmpb_wr) m_ocrb = cmp_wdata;
    check(tag);
    tick_en = 0; cnt_wr = 0; cmpa_wr = 0; cmpb_wr = 0; flag_clr = 0; irq_ack = 0;
  endtask

  task automatic wr_cnt(input logic [15:0] v, input string tag);
    cnt_wr = 1; cnt_wdata = v; step(tag);
  endtask

  task automatic wr_cmp(input logic a, input logic [15:0] v, input string tag);
    if (a) cmpa_wr = 1; else cmpb_wr = 1;
    cmp_wdata = v; step(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin tick_en = 1; step(tag); end
  endtask

  task automatic clear_all;
    flag_clr = 3'b111; step("R10");
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; mode_sel = 0; tick_en = 0; cnt_wr = 0; cmpa_wr = 0; cmpb_wr = 0;
    cnt_wdata = 0; cmp_wdata = 0; flag_clr = 0; irq_ack = 0; irq_en = 3'b111;
    m_cnt = 0; m_ocra = 0; m_ocrb = 0; m_flags = 0; m_blk = 0;
    repeat (3) @(negedge clk);
    check("R4 reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R4 after reset");

    // compare values away from test windows
    wr_cmp(1, 16'h0040, "R9"); wr_cmp(0, 16'h0041, "R9");

    // R2 / R5: 8-bit wrap, high data byte dropped
    mode_sel = 3'b000;
    wr_cnt(16'hABFD, "R2 write low byte");
    ticks(1, "R8 blocked tick"); ticks(3, "R2 R5 wrap");
    step("R4 hold");
    clear_all();

    // R3 / R1: 16-bit wrap, and x-bit variant
    mode_sel = 3'b010;
    wr_cnt(16'hFFFE, "R3 write"); ticks(3, "R3 R5 wrap16");
    mode_sel = 3'b011;
    wr_cnt(16'h00FE, "R1 mode 011"); ticks(3, "R1 R3 carry");
    mode_sel = 3'b111; ticks(2, "R1 capture16");
    mode_sel = 3'b101;
    wr_cnt(16'h00FE, "R1 capture8"); ticks(3, "R1 R2 capture8 wrap");
    clear_all();

    // R6: 16-bit single channel
    mode_sel = 3'b010;
    wr_cmp(1, 16'h0105, "R9"); wr_cmp(0, 16'h0005, "R9");
    wr_cnt(16'h0103, "R6"); ticks(4, "R6 A only 16-bit");
    wr_cnt(16'h0003, "R6"); ticks(4, "R6 B silent 16-bit");
    clear_all();
    mode_sel = 3'b000;
    wr_cmp(0, 16'h0007, "R9");
    wr_cnt(16'h0003, "R6"); ticks(6, "R6 A and B 8-bit");
    clear_all();

    // R7: clear-on-compare
    mode_sel = 3'b001;
    wr_cmp(1, 16'h0003, "R9");
    wr_cnt(16'h0000, "R7"); ticks(9, "R7 reload");
    clear_all();

    // R8: write equal to compare, idle gap, blocked then live
    mode_sel = 3'b000;
    wr_cmp(1, 16'h0010, "R9");
    wr_cnt(16'h0010, "R8"); step("R8 idle"); step("R8 idle");
    ticks(1, "R8 blocked"); ticks(1, "R8 no match");
    wr_cnt(16'h000F, "R8"); ticks(3, "R8 live match");
    mode_sel = 3'b001;
    wr_cnt(16'h0010, "R8 ctc"); ticks(2, "R8 R7 blocked reload");
    tick_en = 1; cnt_wr = 1; cnt_wdata = 16'h0010; step("R4 R8 write wins");
    ticks(2, "R8 after write");
    clear_all();

    // R9: immediate compare update
    mode_sel = 3'b000;
    wr_cnt(16'h0020, "R9"); ticks(1, "R9");
    wr_cmp(0, 16'h0021, "R9 write B"); ticks(1, "R9 immediate B");

    // R10 / R11
    irq_en = 3'b101; step("R11 mask");
    irq_en = 3'b010; step("R11 mask");
    wr_cnt(16'h0030, "R10"); ticks(1, "R10");
    wr_cmp(1, 16'h0031, "R10");
    tick_en = 1; flag_clr = 3'b010; step("R10 set wins");
    irq_ack = 3'b010; step("R10 ack clears");
    flag_clr = 3'b100; step("R10 clear B");
    irq_en = 3'b111;

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) < 2) mode_sel = 3'($urandom_range(0, 7));
      tick_en = ($urandom_range(0, 99) < 60);
      if ($urandom_range(0, 99) < 5) begin
        cnt_wr = 1; cnt_wdata = 16'($urandom_range(0, 24));
        if ($urandom_range(0, 3) == 0) cnt_wdata = 16'($urandom);
      end
      if ($urandom_range(0, 99) < 3) begin
        cmp_wdata = 16'($urandom_range(0, 24));
        if ($urandom_range(0, 1) == 0) cmpa_wr = 1; else cmpb_wr = 1;
      end
      if ($urandom_range(0, 99) < 5) flag_clr = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 99) < 5) irq_ack  = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 99) < 3) irq_en   = 3'($urandom_range(0, 7));
      step("R2 R3 R5 R6 R7 R8 R10 R11 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule